// File: doc/BRIEF.md
# Interrupt Pin Servicing with Remote IRR

This block sits between a set of interrupt input pins and the logic that delivers interrupt messages to processors. For every pin it applies the configured polarity, keeps a pending bit, and decides when the pin needs service. Pins needing service are handed one at a time, lowest index first, to the delivery logic through a request/acknowledge pair. The acknowledge carries a flag that says whether the message reached at least one target.

Edge-triggered pins raise one request per rising effective edge, and their pending bit drops once that request is serviced. This happens even when the entry is masked. Level-triggered pins carry a remote-IRR bit, which is set when a delivery lands. While it is set, a new rising level gets no service. An end-of-interrupt message whose vector equals the entry's vector clears the bit, and if the pin is still asserted and unmasked it is serviced again. Software rewriting an entry is signalled by a one-cycle pulse with the pin index. If that pin is pending, the write requests service again.

Configuration (polarity, trigger mode, mask, vector) comes in as per-pin vectors owned by the surrounding register logic. Destination resolution is not part of this block.

Top module: `irq_pin_service`

## Requirements
- R1: The effective level of a pin is its input level XOR its polarity bit (polarity 1 = active low). For a level-triggered pin, `pending` equals the effective level sampled at the previous clock edge.
- R2: An edge-triggered pin sets its pending bit and records a service request on a 0-to-1 change of its effective level. Its pending bit clears at the edge that completes its service, whether the entry is masked or not. It clears earlier if the effective level falls.
- R3: A level-triggered pin records a service request on a rising effective level only while its remote-IRR bit is clear.
- R4: Serving an unmasked pin raises `dlv_req` with `dlv_pin` equal to its index. Both hold steady until `dlv_ack`, and `dlv_req` drops at the acknowledging edge. Serving a masked pin completes in one cycle without raising `dlv_req`.
- R5: An acknowledge with `dlv_hit`=1 for a level-triggered pin sets that pin's remote-IRR bit. An acknowledge with `dlv_hit`=0, or for an edge pin, leaves it clear.
- R6: An end-of-interrupt (`eoi_valid`) whose vector equals a level-triggered entry's vector clears that entry's remote-IRR bit. If the entry is unmasked and pending, it records a new request. Entries with other vectors, and edge entries, are unaffected.
- R7: A `cfg_wr` pulse naming a pin whose pending bit is set records a service request, even if remote IRR is set. A pulse naming a pin that is not pending has no effect.
- R8: When several pins have requests, the lowest index is served first. The others stay recorded until served.
- R9: Synchronous reset clears every pending, remote-IRR and request bit and drops `dlv_req`.
- R10: `dlv_req` rises at the second clock edge after the input change that triggers service: one edge to record the request, one to grant it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_PINS | Raw interrupt input levels |
| cfg_polarity | input | NUM_PINS | 1 = pin is active low |
| cfg_level | input | NUM_PINS | 1 = level-triggered, 0 = edge-triggered |
| cfg_mask | input | NUM_PINS | 1 = entry masked |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_wr | input | 1 | One-cycle pulse: an entry was rewritten |
| cfg_wr_pin | input | IDX_W | Index of the rewritten entry |
| eoi_valid | input | 1 | End-of-interrupt message valid |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_req | output | 1 | Delivery request to the delivery logic |
| dlv_pin | output | IDX_W | Pin index of the current request |
| dlv_ack | input | 1 | Delivery logic finished the request |
| dlv_hit | input | 1 | With `dlv_ack`: at least one target was reached |
| pending | output | NUM_PINS | Per-pin pending register |

## Verification
A stuck or lost remote-IRR bit shows at the ports in one of two ways. A level pin that should be blocked raises `dlv_req` two edges after its level rises. A pin that should be released stays silent after a matching end-of-interrupt. Toggling the pin after a no-hit acknowledge shows which case applies. A wrong pending bit on an edge pin shows on `pending` one edge after the serviced acknowledge or masked grant. Arbitration errors show as the wrong `dlv_pin` on the first request after a simultaneous rise.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

    localparam int VEC_W_DEFAULT = 8;

    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_WAIT = 1'b1
    } svc_state_t;

    typedef struct packed {
        logic polarity;
        logic level_trig;
        logic masked;
    } pin_mode_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N    = 24,
    parameter int IW   = irq_svc_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  want,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any
);

    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]     = want[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | want[i];
        end
    endgenerate

    assign any = blocked[N];

    always_comb begin
        grant_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (want[k]) grant_idx = IW'(k);
        end
    end

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R8
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        any |-> (((grant - N'(1)) & want) == '0)); // R8

endmodule

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
    import irq_svc_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level_in,
    input  pin_mode_t        mode,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             wr_hit,
    input  logic             done,
    input  logic             rirr_set,
    output logic             pending,
    output logic             want
);

    logic eff, eff_q, pending_q, rirr_q, want_q;
    logic rise, eoi_match, trigger;

    assign eff       = level_in ^ mode.polarity;
    assign rise      = eff & ~eff_q;
    assign eoi_match = eoi_valid & mode.level_trig & (vector == eoi_vector);

    always_comb begin
        trigger = 1'b0;
        if (rise && (!mode.level_trig || !rirr_q)) trigger = 1'b1;
        if (eoi_match && !mode.masked && pending_q) trigger = 1'b1;
        if (wr_hit && pending_q) trigger = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eff_q     <= 1'b0;
            pending_q <= 1'b0;
            rirr_q    <= 1'b0;
            want_q    <= 1'b0;
        end else begin
            eff_q <= eff;
            if (mode.level_trig) pending_q <= eff;
            else                 pending_q <= eff & (rise | (pending_q & ~done));
            if (eoi_match)       rirr_q <= 1'b0;
            else if (rirr_set)   rirr_q <= 1'b1;
            want_q <= (want_q & ~done) | trigger;
        end
    end

    assign pending = pending_q;
    assign want    = want_q;

    AST_EOI_CLEARS_RIRR: assert property (@(posedge clk) disable iff (rst)
        eoi_match |=> !rirr_q); // R6
    AST_EDGE_PEND_DROP: assert property (@(posedge clk) disable iff (rst)
        (done && !mode.level_trig && !rise) |=> !pending_q); // R2
    AST_RIRR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(rirr_q) |-> $past(rirr_set)); // R5

endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = VEC_W_DEFAULT,
    parameter int IDX_W    = idx_width(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PINS-1:0]       pin_level,
    input  logic [NUM_PINS-1:0]       cfg_polarity,
    input  logic [NUM_PINS-1:0]       cfg_level,
    input  logic [NUM_PINS-1:0]       cfg_mask,
    input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
    input  logic                      cfg_wr,
    input  logic [IDX_W-1:0]          cfg_wr_pin,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    output logic                      dlv_req,
    output logic [IDX_W-1:0]          dlv_pin,
    input  logic                      dlv_ack,
    input  logic                      dlv_hit,
    output logic [NUM_PINS-1:0]       pending
);

    svc_state_t             state;
    logic [IDX_W-1:0]       cur_pin;
    logic [NUM_PINS-1:0]    want_vec, grant, done_vec, rirr_vec;
    logic [IDX_W-1:0]       pick;
    logic                   any_want;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            pin_mode_t m;
            assign m = '{polarity: cfg_polarity[i], level_trig: cfg_level[i],
                         masked: cfg_mask[i]};
            irq_pin_slot #(.VEC_W(VEC_W)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .level_in   (pin_level[i]),
                .mode       (m),
                .vector     (cfg_vector[i*VEC_W +: VEC_W]),
                .eoi_valid  (eoi_valid),
                .eoi_vector (eoi_vector),
                .wr_hit     (cfg_wr && (cfg_wr_pin == IDX_W'(i))),
                .done       (done_vec[i]),
                .rirr_set   (rirr_vec[i]),
                .pending    (pending[i]),
                .want       (want_vec[i])
            );
        end
    endgenerate

    irq_prio_pick #(.N(NUM_PINS), .IW(IDX_W)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .want      (want_vec),
        .grant     (grant),
        .grant_idx (pick),
        .any       (any_want)
    );

    always_comb begin
        done_vec = '0;
        rirr_vec = '0;
        if (state == SVC_IDLE) begin
            if (any_want && cfg_mask[pick]) done_vec = grant;
        end else if (dlv_ack) begin
            done_vec[cur_pin] = 1'b1;
            rirr_vec[cur_pin] = dlv_hit & cfg_level[cur_pin];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SVC_IDLE;
            cur_pin <= '0;
        end else begin
            case (state)
                SVC_IDLE: if (any_want && !cfg_mask[pick]) begin
                    state   <= SVC_WAIT;
                    cur_pin <= pick;
                end
                SVC_WAIT: if (dlv_ack) state <= SVC_IDLE;
                default:  state <= SVC_IDLE;
            endcase
        end
    end

    assign dlv_req = (state == SVC_WAIT);
    assign dlv_pin = cur_pin;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && !dlv_ack) |=> (dlv_req && $stable(dlv_pin))); // R4
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_ack) |=> !dlv_req); // R4
    AST_REQ_RECORDED: assert property (@(posedge clk) disable iff (rst)
        dlv_req |-> want_vec[dlv_pin]); // R8

endmodule

// File: tb/irq_pin_service_test.sv
module irq_pin_service_test;

    localparam int N  = 4;
    localparam int VW = 8;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    pin_level = 4'b1000;
    logic [N-1:0]    cfg_polarity = 4'b1000;
    logic [N-1:0]    cfg_level = 4'b0101;
    logic [N-1:0]    cfg_mask = 4'b0100;
    logic [N*VW-1:0] cfg_vector = {8'h33, 8'h30, 8'h31, 8'h30};
    logic            cfg_wr = 1'b0;
    logic [IW-1:0]   cfg_wr_pin = '0;
    logic            eoi_valid = 1'b0;
    logic [VW-1:0]   eoi_vector = '0;
    logic            dlv_req;
    logic [IW-1:0]   dlv_pin;
    logic            dlv_ack = 1'b0;
    logic            dlv_hit = 1'b0;
    logic [N-1:0]    pending;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_pin_service #(.NUM_PINS(N), .VEC_W(VW), .IDX_W(IW)) uut (
        .clk(clk), .rst(rst), .pin_level(pin_level), .cfg_polarity(cfg_polarity),
        .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_vector(cfg_vector),
        .cfg_wr(cfg_wr), .cfg_wr_pin(cfg_wr_pin), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .dlv_req(dlv_req), .dlv_pin(dlv_pin),
        .dlv_ack(dlv_ack), .dlv_hit(dlv_hit), .pending(pending)
    );

    typedef struct packed {
        logic [3:0] lvl;
        logic       ack;
        logic       hit;
        logic       eoi;
        logic [7:0] ev;
        logic       req;
        logic [1:0] pin;
        logic [3:0] pend;
    } vec_t;

    // pins 0,2 level (2 masked), pin 1 edge, pin 3 edge active low
    localparam vec_t TBL [29] = '{
        '{4'b1000,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0000},
        '{4'b1001,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1001,1'b0,1'b0,1'b0,8'h00,1'b1,2'd0,4'b0001},
        '{4'b1001,1'b1,1'b1,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1000,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0000},
        '{4'b1001,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1001,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1001,1'b0,1'b0,1'b1,8'h31,1'b0,2'd0,4'b0001},
        '{4'b1001,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1001,1'b0,1'b0,1'b1,8'h30,1'b0,2'd0,4'b0001},
        '{4'b1001,1'b0,1'b0,1'b0,8'h00,1'b1,2'd0,4'b0001},
        '{4'b1001,1'b1,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1011,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0011},
        '{4'b1011,1'b0,1'b0,1'b0,8'h00,1'b1,2'd1,4'b0011},
        '{4'b1011,1'b1,1'b1,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1011,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1010,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0000},
        '{4'b1011,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1011,1'b0,1'b0,1'b0,8'h00,1'b1,2'd0,4'b0001},
        '{4'b1011,1'b1,1'b1,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b1001,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b0011,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b1011},
        '{4'b0011,1'b0,1'b0,1'b0,8'h00,1'b1,2'd1,4'b1011},
        '{4'b0011,1'b1,1'b1,1'b0,8'h00,1'b0,2'd0,4'b1001},
        '{4'b0011,1'b0,1'b0,1'b0,8'h00,1'b1,2'd3,4'b1001},
        '{4'b0011,1'b1,1'b1,1'b0,8'h00,1'b0,2'd0,4'b0001},
        '{4'b0111,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0101},
        '{4'b0111,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0101},
        '{4'b0111,1'b0,1'b0,1'b0,8'h00,1'b0,2'd0,4'b0101}
    };

    function automatic string row_tag(input int k);
        if (k == 0)  return "R9";
        if (k <= 2)  return "R10";
        if (k <= 3)  return "R4";
        if (k <= 6)  return "R3";
        if (k <= 10) return "R6";
        if (k <= 11) return "R5";
        if (k <= 16) return "R2";
        if (k <= 19) return "R5";
        if (k <= 21) return "R1";
        if (k <= 25) return "R8";
        return "R4";
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "reset pending", int'(pending), 0);
        check("R9", "reset req", int'(dlv_req), 0);
        rst = 1'b0;

        for (int k = 0; k < 29; k++) begin
            pin_level  = TBL[k].lvl;
            dlv_ack    = TBL[k].ack;
            dlv_hit    = TBL[k].hit;
            eoi_valid  = TBL[k].eoi;
            eoi_vector = TBL[k].ev;
            step();
            check(row_tag(k), "dlv_req", int'(dlv_req), int'(TBL[k].req));
            if (TBL[k].req) check(row_tag(k), "dlv_pin", int'(dlv_pin), int'(TBL[k].pin));
            check(row_tag(k), "pending", int'(pending), int'(TBL[k].pend));
        end
        dlv_ack = 1'b0; dlv_hit = 1'b0; eoi_valid = 1'b0;

        // R7: write to pending pin 0 (remote IRR set) retriggers it
        cfg_wr = 1'b1; cfg_wr_pin = 2'd0;
        step();
        cfg_wr = 1'b0;
        check("R7", "req after write edge", int'(dlv_req), 0);
        step();
        check("R7", "req from write", int'(dlv_req), 1);
        check("R7", "pin from write", int'(dlv_pin), 0);
        dlv_ack = 1'b1; dlv_hit = 1'b1;
        step();
        dlv_ack = 1'b0; dlv_hit = 1'b0;
        check("R4", "req drops on ack", int'(dlv_req), 0);

        // R7: write to non-pending pin 3 does nothing
        cfg_wr = 1'b1; cfg_wr_pin = 2'd3;
        step();
        cfg_wr = 1'b0;
        repeat (3) step();
        check("R7", "no req for idle write", int'(dlv_req), 0);

        // R2: masked edge pin still drops pending after service
        cfg_mask = 4'b0110;
        pin_level = 4'b0101;
        step();
        check("R2", "edge fall pending", int'(pending), 4'b0101);
        pin_level = 4'b0111;
        step();
        check("R2", "masked edge set", int'(pending), 4'b0111);
        step();
        check("R2", "masked edge cleared", int'(pending), 4'b0101);
        check("R4", "masked no req", int'(dlv_req), 0);

        // R9: mid-run reset
        rst = 1'b1;
        step();
        check("R9", "reset pending", int'(pending), 0);
        check("R9", "reset req", int'(dlv_req), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule